// File: doc/BRIEF.md
# ECC Error Capture Register

This block sits beside the ECC checker of a memory controller. The checker reports corrected (single-bit) and uncorrectable (multi-bit) errors as one-cycle strobes, with the 8-bit syndrome and the 32-bit physical address of the access. The block records only the first error it sees after software has re-armed it. It keeps a status flag for the class of that error, the syndrome and the upper 19 address bits. Everything is presented as one 32-bit register. Software reads this register, then writes ones to the status bits to clear them and re-arm capture.

Three control bits live in the same register. One enables a non-maskable interrupt pulse when a corrected error is captured. One enables a bus system-error pulse when an uncorrectable error is captured. One disables the automatic scrub write-back that is normally requested for every corrected read; the scrub request carries the full failing address.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset the register reads 0x00000000, and nmiReq, serrReq and scrubReq are low.
- R2: Bit 31 (scrub disable) is written from regWrData[31] when regByteEn[3] is set. Bit 3 (system-error enable) and bit 2 (interrupt enable) are written from regWrData[3:2] when regByteEn[0] is set. Bits 30:4 ignore writes, and bytes whose enable bit is low are not changed.
- R3: When both status bits are 0 and an error strobe is high at a clock edge, the register after that edge holds errAddr[31:13] in bits 30:12 and the syndrome in bits 11:4. It sets bit 0 for a corrected error or bit 1 for an uncorrectable error, and never both.
- R4: While bit 0 or bit 1 is set, further error strobes change neither bits 30:4 nor bits 1:0.
- R5: A write with regByteEn[0] set clears bit 0 when regWrData[0] is 1 and clears bit 1 when regWrData[1] is 1. A 0 in those positions leaves the bit unchanged. Capture is re-armed only when both bits are 0.
- R6: If ceStrobe and ueStrobe are both high while capture is armed, the uncorrectable error is captured: bit 1 is set and bit 0 stays 0.
- R7: nmiReq is high for exactly the one cycle after the edge that captures a corrected error, provided bit 2 was 1 before that edge. Otherwise it stays low.
- R8: serrReq is high for exactly the one cycle after the edge that captures an uncorrectable error, provided bit 3 was 1 before that edge. Otherwise it stays low.
- R9: Every ceStrobe seen while bit 31 is 0 gives a one-cycle scrubReq after the edge, whether or not the error is captured. During that pulse scrubAddr equals the full errAddr. When bit 31 is 1, no scrubReq is issued.
- R10: An error strobe in the same cycle as a write that clears a set status bit is dropped. The clear takes effect, and bits 30:4 keep the earlier capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceStrobe | input | 1 | Corrected error on the current read |
| ueStrobe | input | 1 | Uncorrectable error on the current read |
| syndrome | input | 8 | ECC syndrome of the current read |
| errAddr | input | 32 | Physical address of the current read |
| regWrEn | input | 1 | Register write strobe |
| regByteEn | input | 4 | Byte enables of the write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Current register value |
| nmiReq | output | 1 | Non-maskable interrupt pulse |
| serrReq | output | 1 | Bus system-error pulse |
| scrubReq | output | 1 | Scrub write-back request pulse |
| scrubAddr | output | 32 | Address to scrub, valid with scrubReq |

## Verification
Two kinds of collision can land on the same clock edge. In the first, both error classes arrive together. In the second, an error arrives while software writes to clear the status bits. Directed cycles drive each case on purpose: both strobes high while armed, and a strobe together with a clearing write while a flag is set. The random phase produces further collisions by mixing frequent strobes with occasional writes. A bench model decides each outcome from the rules (the uncorrectable error wins; an error during a clear is dropped but its scrub still occurs) and compares the full register and all pulses every cycle.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int REG_W = 32;
  localparam int CTL_BITS = 4;

  typedef struct packed {
    logic capture;
    logic scrubLoad;
  } dpStrobe_t;
endpackage

// File: rtl/ecc_cap_ctl.sv
module ecc_cap_ctl
  import ecc_cap_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            ceStrobe,
  input  logic            ueStrobe,
  input  logic            regWrEn,
  input  logic [3:0]      regByteEn,
  input  logic [REG_W-1:0] regWrData,
  output dpStrobe_t       strobe,
  output logic            sbeFlag,
  output logic            mbeFlag,
  output logic            scrubDis,
  output logic            nmiEn,
  output logic            serrEn,
  output logic            nmiReq,
  output logic            serrReq,
  output logic            scrubReq
);
  logic armed, capture, wrLo, wrHi, scrubFire;

  assign armed     = !sbeFlag && !mbeFlag;
  assign capture   = armed && (ceStrobe || ueStrobe);
  assign wrLo      = regWrEn && regByteEn[0];
  assign wrHi      = regWrEn && regByteEn[3];
  assign scrubFire = ceStrobe && !scrubDis;

  assign strobe.capture   = capture;
  assign strobe.scrubLoad = scrubFire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sbeFlag  <= 1'b0;
      mbeFlag  <= 1'b0;
      scrubDis <= 1'b0;
      nmiEn    <= 1'b0;
      serrEn   <= 1'b0;
      nmiReq   <= 1'b0;
      serrReq  <= 1'b0;
      scrubReq <= 1'b0;
    end else begin
      if (wrHi) scrubDis <= regWrData[REG_W-1];
      if (wrLo) begin
        nmiEn  <= regWrData[2];
        serrEn <= regWrData[3];
      end
      if (capture) begin
        mbeFlag <= ueStrobe;
        sbeFlag <= !ueStrobe;
      end else begin
        if (wrLo && regWrData[0]) sbeFlag <= 1'b0;
        if (wrLo && regWrData[1]) mbeFlag <= 1'b0;
      end
      nmiReq   <= capture && !ueStrobe && nmiEn;
      serrReq  <= capture && ueStrobe && serrEn;
      scrubReq <= scrubFire;
    end
  end

  AST_SINGLE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    !(sbeFlag && mbeFlag)); // R3
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((sbeFlag || mbeFlag) && !(regWrEn && regByteEn[0])) |=> $stable({sbeFlag, mbeFlag})); // R4
  AST_UE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (!sbeFlag && !mbeFlag && ceStrobe && ueStrobe) |=> (mbeFlag && !sbeFlag)); // R6
  AST_NMI_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |-> (sbeFlag && $past(nmiEn))); // R7
  AST_SERR_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    serrReq |-> (mbeFlag && $past(serrEn))); // R8
  AST_SCRUB_QUAL: assert property (@(posedge clk) disable iff (!rstN)
    scrubReq |-> $past(ceStrobe && !scrubDis)); // R9
endmodule

// File: rtl/ecc_cap_dp.sv
module ecc_cap_dp
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 8,
  parameter int KEEP_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] errAddr,
  input  logic [SYN_W-1:0]  syndrome,
  output logic [KEEP_W-1:0] addrHigh,
  output logic [SYN_W-1:0]  synReg,
  output logic [ADDR_W-1:0] scrubAddr
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrHigh  <= '0;
      synReg    <= '0;
      scrubAddr <= '0;
    end else begin
      if (strobe.capture) begin
        addrHigh <= errAddr[ADDR_W-1 -: KEEP_W];
        synReg   <= syndrome;
      end
      if (strobe.scrubLoad) scrubAddr <= errAddr;
    end
  end

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(addrHigh) && $stable(synReg))); // R4
  AST_SCRUB_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.scrubLoad |=> (scrubAddr == $past(errAddr))); // R9
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceStrobe,
  input  logic              ueStrobe,
  input  logic [SYN_W-1:0]  syndrome,
  input  logic [ADDR_W-1:0] errAddr,
  input  logic              regWrEn,
  input  logic [3:0]        regByteEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              nmiReq,
  output logic              serrReq,
  output logic              scrubReq,
  output logic [ADDR_W-1:0] scrubAddr
);
  localparam int KEEP_W = REG_W - 1 - CTL_BITS - SYN_W;

  dpStrobe_t          strobe;
  logic               sbeFlag, mbeFlag, scrubDis, nmiEn, serrEn;
  logic [KEEP_W-1:0]  addrHigh;
  logic [SYN_W-1:0]   synReg;

  ecc_cap_ctl u_ctl (
    .clk(clk), .rstN(rstN), .ceStrobe(ceStrobe), .ueStrobe(ueStrobe),
    .regWrEn(regWrEn), .regByteEn(regByteEn), .regWrData(regWrData),
    .strobe(strobe), .sbeFlag(sbeFlag), .mbeFlag(mbeFlag),
    .scrubDis(scrubDis), .nmiEn(nmiEn), .serrEn(serrEn),
    .nmiReq(nmiReq), .serrReq(serrReq), .scrubReq(scrubReq)
  );

  ecc_cap_dp #(.ADDR_W(ADDR_W), .SYN_W(SYN_W), .KEEP_W(KEEP_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .errAddr(errAddr),
    .syndrome(syndrome), .addrHigh(addrHigh), .synReg(synReg),
    .scrubAddr(scrubAddr)
  );

  assign regRdData = {scrubDis, addrHigh, synReg, serrEn, nmiEn, mbeFlag, sbeFlag};
endmodule

// File: tb/sim_ecc_err_capture.sv
module sim_ecc_err_capture;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceStrobe = 1'b0, ueStrobe = 1'b0, regWrEn = 1'b0;
  logic [7:0]  syndrome = '0;
  logic [31:0] errAddr = '0, regWrData = '0;
  logic [3:0]  regByteEn = '0;
  logic [31:0] regRdData, scrubAddr;
  logic nmiReq, serrReq, scrubReq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic mScrubDis, mNmiEn, mSerrEn, mSbe, mMbe;
  logic [18:0] mAddr;
  logic [7:0]  mSyn;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_err_capture u0 (
    .clk(clk), .rstN(rstN), .ceStrobe(ceStrobe), .ueStrobe(ueStrobe),
    .syndrome(syndrome), .errAddr(errAddr), .regWrEn(regWrEn),
    .regByteEn(regByteEn), .regWrData(regWrData), .regRdData(regRdData),
    .nmiReq(nmiReq), .serrReq(serrReq), .scrubReq(scrubReq),
    .scrubAddr(scrubAddr)
  );

  function automatic logic [31:0] expReg();
    return {mScrubDis, mAddr, mSyn, mSerrEn, mNmiEn, mMbe, mSbe};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic ce, input logic ue, input logic [7:0] syn,
                     input logic [31:0] addr, input logic we,
                     input logic [3:0] be, input logic [31:0] wd,
                     input string tag);
    logic cap, eNmi, eSerr, eScrub;
    cap    = !mSbe && !mMbe && (ce || ue);
    eNmi   = cap && !ue && mNmiEn;
    eSerr  = cap && ue && mSerrEn;
    eScrub = ce && !mScrubDis;
    if (we && be[3]) mScrubDis = wd[31];
    if (we && be[0]) begin mNmiEn = wd[2]; mSerrEn = wd[3]; end
    if (cap) begin
      mMbe = ue; mSbe = !ue; mAddr = addr[31:13]; mSyn = syn;
    end else begin
      if (we && be[0] && wd[0]) mSbe = 1'b0;
      if (we && be[0] && wd[1]) mMbe = 1'b0;
    end
    ceStrobe = ce; ueStrobe = ue; syndrome = syn; errAddr = addr;
    regWrEn = we; regByteEn = be; regWrData = wd;
    @(posedge clk);
    @(negedge clk);
    ceStrobe = 1'b0; ueStrobe = 1'b0; regWrEn = 1'b0;
    check(tag, "register", regRdData, expReg());
    check(tag, "nmiReq", {31'd0, nmiReq}, {31'd0, eNmi});
    check(tag, "serrReq", {31'd0, serrReq}, {31'd0, eSerr});
    check(tag, "scrubReq", {31'd0, scrubReq}, {31'd0, eScrub});
    if (eScrub) check(tag, "scrubAddr", scrubAddr, addr);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 1'b0, 8'h00, 32'h0, 1'b0, 4'h0, 32'h0, tag);
  endtask

  initial begin
    mScrubDis = 0; mNmiEn = 0; mSerrEn = 0; mSbe = 0; mMbe = 0;
    mAddr = '0; mSyn = '0;
    repeat (3) @(negedge clk);
    check("R1", "register", regRdData, 32'h0);
    check("R1", "pulses", {29'd0, nmiReq, serrReq, scrubReq}, 32'h0);
    rstN = 1'b1;
    idle("R1");

    // R2: control bits, byte enables, read-only fields
    cyc(0, 0, 0, 0, 1, 4'b1001, 32'h8000_000C, "R2");
    cyc(0, 0, 0, 0, 1, 4'b0110, 32'hFFFF_FFFF, "R2");
    cyc(0, 0, 0, 0, 1, 4'b0001, 32'h7FFF_FFF4, "R2");
    cyc(0, 0, 0, 0, 1, 4'b1000, 32'h0000_0000, "R2");

    // R3 and R7: corrected error captured with interrupt enabled
    cyc(1, 0, 8'h5A, 32'hDEAD_BEEF, 0, 0, 0, "R3");
    idle("R7");
    // R4: later errors ignored while flag set
    cyc(0, 1, 8'hC3, 32'h1234_5678, 0, 0, 0, "R4");
    cyc(1, 0, 8'h11, 32'hFFFF_E000, 0, 0, 0, "R4");
    // R5: zero write no effect, then clear
    cyc(0, 0, 0, 0, 1, 4'b0001, 32'h0000_0004, "R5");
    cyc(0, 0, 0, 0, 1, 4'b0001, 32'h0000_0005, "R5");
    // R6 and R8: simultaneous classes, system-error enabled
    cyc(0, 0, 0, 0, 1, 4'b0001, 32'h0000_0008, "R8");
    cyc(1, 1, 8'h99, 32'hA5A5_0000, 0, 0, 0, "R6");
    // R10: error during clear is dropped
    cyc(1, 0, 8'h22, 32'h0BAD_F00D, 1, 4'b0001, 32'h0000_000A, "R10");
    idle("R10");
    cyc(0, 1, 8'h44, 32'h8765_4321, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 1, 4'b0001, 32'h0000_0003, "R5");
    // R9: scrub with disable off and on
    cyc(1, 0, 8'h01, 32'hCAFE_1234, 0, 0, 0, "R9");
    cyc(1, 0, 8'h02, 32'h0000_2468, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 1, 4'b1000, 32'h8000_0000, "R9");
    cyc(1, 0, 8'h03, 32'h1357_9BDF, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 1, 4'b1001, 32'h0000_0003, "R9");

    // random phase, fixed seed
    void'($urandom(32'h5EED));
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[3:0] < 4, r[7:4] < 2, 8'($urandom), $urandom,
          r[11:8] < 3, 4'($urandom), $urandom, "RND");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule